// File: doc/BRIEF.md
# General-purpose I/O controller with pin interrupts

This block is a memory-mapped general-purpose I/O peripheral on an APB-style slave bus. It has up to four banks of up to 32 pins each. Every bank has a software-written output value, a software-written drive enable, and a read-only view of the pad inputs after a two-flop synchroniser. Software drives a pin by setting its drive-enable bit and output value. It reads any pin, driven or not, through the input view.

Bank zero adds per-pin interrupt logic. Each pin has an enable bit, a mask bit, a sensitivity-type bit (edge or level), an active-sense bit (rising/high or falling/low), an optional debounce filter, and a write-one-to-clear acknowledge for latched edge events. The qualified per-pin status bits are ORed onto a single interrupt output. The debounce filter works from a slow clock-enable pulse. A strap input chooses one of two address layouts for the interrupt registers. Detection of both edges is left to software, which flips the sense bit after each event.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset every output value, drive enable and interrupt register is zero. A write to bank p at offset 12*p sets that bank's pad output, and a write at 12*p+4 sets its pad drive enable. Both take effect on the next clock and read back at the same offsets.
- R2: A read at offset 0x50+4*p returns bank p's pad inputs as they were two clocks earlier, after the two-flop synchroniser.
- R3: With the layout strap low, the bank-zero interrupt registers are: enable 0x30, mask 0x34, type 0x38, sense 0x3C, status 0x40 (read-only), debounce enable 0x48, acknowledge 0x4C (write-only, reads zero).
- R4: With the layout strap high, the type register moves to 0x34, sense to 0x38, status to 0x3C, acknowledge to 0x40 and mask to 0x44. Enable, debounce enable and all bank registers keep their offsets.
- R5: A pin whose type bit is 0 is level-sensitive. Its status bit is the live input when its sense bit is 1, and the inverted input when its sense bit is 0.
- R6: A pin whose type bit is 1 is edge-sensitive. A rising edge (sense 1) or a falling edge (sense 0) latches a flag, and the flag stays set after the input returns.
- R7: Writing 1 to a bit of the acknowledge register clears that pin's latched edge flag and leaves the other pins' flags alone. Writing all ones clears every flag.
- R8: A status bit reads 1 only when its enable bit is 1 and its mask bit is 0. Edges that occur while a pin's enable bit is 0 are not latched.
- R9: The interrupt output is the OR of all status bits.
- R10: On a pin with its debounce bit set, the interrupt logic sees a new input value only after the value has been sampled identically on two consecutive slow-tick pulses. A pin with its debounce bit clear follows the synchronised input directly.
- R11: Writes to read-only or unused offsets change nothing, and reads of unused offsets return zero.
- R12: Input changes on banks other than bank zero never set a status bit or the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| layout_alt | input | 1 | Strap: 1 selects the alternate interrupt-register layout |
| db_tick | input | 1 | Slow clock-enable pulse for the debounce filter |
| pad_in | input | NUM_PORTS*PORT_W | Pad input values, bank p at bits [p*PORT_W +: PORT_W] |
| pad_out | output | NUM_PORTS*PORT_W | Pad output values |
| pad_oe | output | NUM_PORTS*PORT_W | Pad drive enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are those where a short glitch must be rejected by the debounce filter. These need a pad change that lands between two slow ticks and is then undone before the next tick. The bench controls the tick input directly, so it places each pad change and tick in a chosen cycle. It checks that a glitch straddling two ticks leaves the filtered level unchanged, and that a steady value passes only on the second tick. Edge flags latched while masked or disabled are reached the same way: the bench fixes the configuration first and then moves the pads.

// File: rtl/gpio_apb_ctrl.sv
`timescale 1ns/1ps
module gpio_apb_ctrl #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                           pclk,
  input  logic                           presetn,
  input  logic                           psel,
  input  logic                           penable,
  input  logic                           pwrite,
  input  logic [ADDR_W-1:0]              paddr,
  input  logic [31:0]                    pwdata,
  output logic [31:0]                    prdata,
  input  logic                           layout_alt,
  input  logic                           db_tick,
  input  logic [NUM_PORTS*PORT_W-1:0]    pad_in,
  output logic [NUM_PORTS*PORT_W-1:0]    pad_out,
  output logic [NUM_PORTS*PORT_W-1:0]    pad_oe,
  output logic                           irq
);
  localparam int NPIN = NUM_PORTS * PORT_W;
  localparam logic [ADDR_W-1:0] OFF_EN  = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] OFF_DEB = ADDR_W'('h48);

  logic [NPIN-1:0]   sync1, sync2;
  logic [PORT_W-1:0] dout [NUM_PORTS];
  logic [PORT_W-1:0] dir  [NUM_PORTS];
  logic [PORT_W-1:0] ien, imask, itype, ipol, deb_en, db_last, db_q, a_prev, eflag;
  logic [PORT_W-1:0] a_raw, a_eff, edge_set, lvl, status, eoi_clr, db_stable;
  logic [ADDR_W-1:0] o_mask, o_type, o_pol, o_stat, o_eoi;
  logic [31:0]       rd;
  logic              wr;

  assign wr     = psel & penable & pwrite;
  assign o_mask = layout_alt ? ADDR_W'('h44) : ADDR_W'('h34);
  assign o_type = layout_alt ? ADDR_W'('h34) : ADDR_W'('h38);
  assign o_pol  = layout_alt ? ADDR_W'('h38) : ADDR_W'('h3C);
  assign o_stat = layout_alt ? ADDR_W'('h3C) : ADDR_W'('h40);
  assign o_eoi  = layout_alt ? ADDR_W'('h40) : ADDR_W'('h4C);

  assign a_raw     = sync2[PORT_W-1:0];
  assign a_eff     = (deb_en & db_q) | (~deb_en & a_raw);
  assign db_stable = ~(a_raw ^ db_last);
  assign edge_set  = ien & itype & ((ipol & a_eff & ~a_prev) | (~ipol & ~a_eff & a_prev));
  assign lvl       = ~(a_eff ^ ipol);
  assign status    = ien & ~imask & ((itype & eflag) | (~itype & lvl));
  assign irq       = |status;
  assign eoi_clr   = (wr && paddr == o_eoi) ? pwdata[PORT_W-1:0] : '0;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_pad
    assign pad_out[g*PORT_W +: PORT_W] = dout[g];
    assign pad_oe [g*PORT_W +: PORT_W] = dir[g];
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      sync1 <= '0; sync2 <= '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        dout[p] <= '0; dir[p] <= '0;
      end
      ien <= '0; imask <= '0; itype <= '0; ipol <= '0; deb_en <= '0;
      db_last <= '0; db_q <= '0; a_prev <= '0; eflag <= '0;
    end else begin
      sync1  <= pad_in;
      sync2  <= sync1;
      a_prev <= a_eff;
      eflag  <= ((eflag & ~eoi_clr) | edge_set) & ien;
      if (db_tick) begin
        db_last <= a_raw;
        db_q    <= (db_stable & a_raw) | (~db_stable & db_q);
      end
      if (wr) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
          if (paddr == ADDR_W'(p*12))     dout[p] <= pwdata[PORT_W-1:0];
          if (paddr == ADDR_W'(p*12 + 4)) dir[p]  <= pwdata[PORT_W-1:0];
        end
        if (paddr == OFF_EN)  ien    <= pwdata[PORT_W-1:0];
        if (paddr == o_mask)  imask  <= pwdata[PORT_W-1:0];
        if (paddr == o_type)  itype  <= pwdata[PORT_W-1:0];
        if (paddr == o_pol)   ipol   <= pwdata[PORT_W-1:0];
        if (paddr == OFF_DEB) deb_en <= pwdata[PORT_W-1:0];
      end
    end
  end

  always_comb begin
    rd = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (paddr == ADDR_W'(p*12))       rd = 32'(dout[p]);
      if (paddr == ADDR_W'(p*12 + 4))   rd = 32'(dir[p]);
      if (paddr == ADDR_W'('h50 + 4*p)) rd = 32'(sync2[p*PORT_W +: PORT_W]);
    end
    if (paddr == OFF_EN)  rd = 32'(ien);
    if (paddr == o_mask)  rd = 32'(imask);
    if (paddr == o_type)  rd = 32'(itype);
    if (paddr == o_pol)   rd = 32'(ipol);
    if (paddr == o_stat)  rd = 32'(status);
    if (paddr == OFF_DEB) rd = 32'(deb_en);
  end
  assign prdata = rd;

  // R1: drive enable of bank zero follows the written value one clock later
  a_r1_oe_follows_dir: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && paddr == ADDR_W'(4)) |=> pad_oe[PORT_W-1:0] == $past(pwdata[PORT_W-1:0]));

  // R7: an all-ones acknowledge with no new event empties every edge flag
  a_r7_ack_all_clears: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && paddr == o_eoi && (&pwdata[PORT_W-1:0]) && edge_set == '0) |=> eflag == '0);

  // R8: a flag can only appear on a pin that was enabled and edge-typed
  a_r8_latch_needs_enable: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> (eflag & ~$past(eflag) & ~$past(ien & itype)) == '0);

  // R8/R9: with every enable bit clear the interrupt line is quiet
  a_r9_irq_quiet_disabled: assert property (@(posedge pclk) disable iff (!presetn)
    (ien == '0) |-> !irq);

  // R10: the filtered value moves only on a slow tick
  a_r10_filter_holds: assert property (@(posedge pclk) disable iff (!presetn)
    !db_tick |=> $stable(db_q));
endmodule

// File: tb/gpio_apb_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_apb_ctrl_bench;
  localparam int NP = 4;
  localparam int PW = 32;

  logic clk = 1'b0, rstn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0, layout_alt = 0, db_tick = 0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [NP*PW-1:0] pad_in = '0, pad_out, pad_oe;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_apb_ctrl u_gpio_apb_ctrl (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .layout_alt(layout_alt),
    .db_tick(db_tick), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  function automatic logic [7:0] off_stat(logic alt); return alt ? 8'h3C : 8'h40; endfunction
  function automatic logic [7:0] off_mask(logic alt); return alt ? 8'h44 : 8'h34; endfunction
  function automatic logic [7:0] off_type(logic alt); return alt ? 8'h34 : 8'h38; endfunction
  function automatic logic [7:0] off_pol (logic alt); return alt ? 8'h38 : 8'h3C; endfunction
  function automatic logic [7:0] off_eoi (logic alt); return alt ? 8'h40 : 8'h4C; endfunction
  function automatic logic [31:0] lvl_status(logic [31:0] en, mk, pol, a);
    return en & ~mk & ~(a ^ pol);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); db_tick = 1;
    @(negedge clk); db_tick = 0;
  endtask

  task automatic done();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    done();
  end

  initial begin
    logic [31:0] v, en, mk, pl, a;
    logic [31:0] exp_dout [NP];
    logic [31:0] exp_dir  [NP];
    void'($urandom(32'd1234));
    for (int p = 0; p < NP; p++) begin exp_dout[p] = '0; exp_dir[p] = '0; end
    idle(3); rstn = 1; idle(2);

    // R1 reset state
    chk("R1 reset oe", pad_oe[31:0], 32'h0);
    chk("R1 reset out", pad_out[127:96], 32'h0);
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    rd(8'h30, v); chk("R1 reset enable", v, 32'h0);

    // R1 random bank writes
    for (int i = 0; i < 20; i++) begin
      int p; logic [31:0] d;
      p = int'($urandom % NP); d = $urandom;
      if (i % 2 == 0) begin wr(8'(12*p), d); exp_dout[p] = d; end
      else begin wr(8'(12*p + 4), d); exp_dir[p] = d; end
      chk("R1 pad out", pad_out[p*PW +: PW], exp_dout[p]);
      chk("R1 pad oe", pad_oe[p*PW +: PW], exp_dir[p]);
      rd(8'(12*p), v);     chk("R1 out readback", v, exp_dout[p]);
      rd(8'(12*p + 4), v); chk("R1 dir readback", v, exp_dir[p]);
    end

    // R2 sampled inputs
    for (int i = 0; i < 6; i++) begin
      pad_in = {$urandom, $urandom, $urandom, $urandom};
      idle(3);
      for (int p = 0; p < NP; p++) begin
        rd(8'(8'h50 + 4*p), v); chk("R2 sampled input", v, pad_in[p*PW +: PW]);
      end
    end
    pad_in = '0; idle(3);

    // R3 default layout
    wr(8'h34, 32'hA5A5_A5A5); wr(8'h38, 32'h0F0F_0F0F); wr(8'h3C, 32'h3C3C_3C3C);
    wr(8'h48, 32'h1234_5678); wr(8'h30, 32'h0);
    rd(8'h34, v); chk("R3 mask", v, 32'hA5A5_A5A5);
    rd(8'h38, v); chk("R3 type", v, 32'h0F0F_0F0F);
    rd(8'h3C, v); chk("R3 sense", v, 32'h3C3C_3C3C);
    rd(8'h48, v); chk("R3 debounce", v, 32'h1234_5678);
    rd(8'h4C, v); chk("R3 ack reads zero", v, 32'h0);
    rd(8'h44, v); chk("R11 unused 0x44 default", v, 32'h0);
    // R4 alternate layout
    layout_alt = 1;
    rd(8'h44, v); chk("R4 mask alt", v, 32'hA5A5_A5A5);
    rd(8'h34, v); chk("R4 type alt", v, 32'h0F0F_0F0F);
    rd(8'h38, v); chk("R4 sense alt", v, 32'h3C3C_3C3C);
    rd(8'h48, v); chk("R4 debounce alt", v, 32'h1234_5678);
    rd(8'h4C, v); chk("R11 unused 0x4C alt", v, 32'h0);
    // R4 alternate ack clears an edge flag
    wr(8'h44, 32'h0); wr(8'h34, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h48, 32'h0); wr(8'h30, 32'hFFFF_FFFF);
    pad_in[31:0] = 32'h0000_0100; idle(4);
    rd(8'h3C, v); chk("R4 alt status", v, 32'h0000_0100);
    wr(8'h40, 32'h0000_0100);
    rd(8'h3C, v); chk("R4 alt ack", v, 32'h0);
    layout_alt = 0; pad_in = '0; idle(3);

    // R5 level sense
    wr(8'h38, 32'h0); wr(8'h34, 32'h0); wr(8'h30, 32'h0000_00FF); wr(8'h3C, 32'h0000_000F);
    pad_in[31:0] = 32'h0000_0033; idle(3);
    rd(8'h40, v); chk("R5 level status", v, 32'h0000_00C3);
    chk("R9 irq on level", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 8; i++) begin
      en = $urandom; mk = (i == 0) ? 32'hFFFF_FFFF : $urandom; pl = $urandom; a = $urandom;
      wr(8'h30, en); wr(8'h34, mk); wr(8'h3C, pl);
      pad_in[31:0] = a; idle(3);
      rd(8'h40, v); chk("R5 R8 level status random", v, lvl_status(en, mk, pl, a));
      chk("R9 irq is OR of status", {31'b0, irq}, {31'b0, |lvl_status(en, mk, pl, a)});
    end

    // R6 edge latch
    wr(8'h30, 32'h0); wr(8'h34, 32'h0); wr(8'h38, 32'hFFFF_FFFF); wr(8'h3C, 32'h0000_FFFF);
    pad_in[31:0] = 32'h0; idle(3);
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R7 clean start", v, 32'h0);
    pad_in[31:0] = 32'hFFFF_FFFF; idle(4);
    rd(8'h40, v); chk("R6 rising edges", v, 32'h0000_FFFF);
    pad_in[31:0] = 32'h0; idle(4);
    rd(8'h40, v); chk("R6 falling edges plus held", v, 32'hFFFF_FFFF);
    wr(8'h4C, 32'h0000_00F0);
    rd(8'h40, v); chk("R7 partial ack", v, 32'hFFFF_FF0F);
    wr(8'h34, 32'hFFFF_0000);
    rd(8'h40, v); chk("R8 mask hides", v, 32'h0000_FF0F);
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R7 ack all", v, 32'h0);
    chk("R9 irq clear", {31'b0, irq}, 32'h0);
    wr(8'h34, 32'h0);
    // R8 no latch while disabled
    wr(8'h30, 32'h0);
    pad_in[31:0] = 32'hFFFF_FFFF; idle(4); pad_in[31:0] = 32'h0; idle(4);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R8 disabled edges dropped", v, 32'h0);
    // R12 other banks
    pad_in[127:32] = {$urandom, $urandom, $urandom}; idle(4);
    pad_in[127:32] = '0; idle(4);
    rd(8'h40, v); chk("R12 other banks silent", v, 32'h0);
    chk("R12 irq silent", {31'b0, irq}, 32'h0);

    // R10 debounce
    wr(8'h38, 32'h0); wr(8'h3C, 32'hFFFF_FFFF); wr(8'h48, 32'h0000_0001);
    pad_in[31:0] = 32'h0; idle(3); tick(); tick();
    pad_in[31:0] = 32'h0000_0003; idle(3);
    rd(8'h40, v); chk("R10 before ticks", v, 32'h0000_0002);
    tick(); idle(1);
    rd(8'h40, v); chk("R10 one tick", v, 32'h0000_0002);
    tick(); idle(1);
    rd(8'h40, v); chk("R10 two ticks", v, 32'h0000_0003);
    pad_in[31:0] = 32'h0000_0002; idle(3); tick();
    pad_in[31:0] = 32'h0000_0003; idle(3); tick(); idle(1);
    rd(8'h40, v); chk("R10 glitch rejected", v, 32'h0000_0003);
    pad_in[31:0] = 32'h0; idle(3); tick(); tick(); idle(1);
    rd(8'h40, v); chk("R10 steady low passes", v, 32'h0);

    // R11 read-only and unused offsets
    pad_in[31:0] = 32'h5A5A_0000; idle(3);
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF); wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h50, v); chk("R11 input view unchanged", v, 32'h5A5A_0000);
    rd(8'h60, v); chk("R11 unused reads zero", v, 32'h0);
    rd(8'h2C, v); chk("R11 gap reads zero", v, 32'h0);
    rd(8'h30, v); chk("R11 enable untouched", v, 32'hFFFF_FFFF);
    chk("R11 pads untouched", pad_out[31:0], exp_dout[0]);

    done();
  end
endmodule